// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a two-wire bus target that fronts a 2048 x 8 byte array. It runs on a fast system clock, oversamples the serial clock and data lines through short synchronizer chains, and recognises bus start and stop events from data edges that occur while the serial clock is high. After a start it collects a control byte. That byte carries a fixed marker bit, three chip-select bits compared against strap pins, three block bits and a direction flag. Only a matching target answers.

A write transfer loads an 11-bit pointer from the block bits and a following word-address byte. Every further byte is then stored at the pointer, unless the protect input is high. A read transfer returns bytes starting at the pointer. To read from a chosen address, the master sends a write header and a word address, then a repeated start and a read header. When the master acknowledges a byte, the next one follows. The pointer advances after each byte in either direction and wraps at the top of the array.

Top module: `sms_target`

## Requirements
- R1: After reset the data-line pull-down is released. A stop event (SDA rising while SCL is high) returns the slave to idle with SDA released, so a byte sent after a stop and without a new start is not acknowledged.
- R2: The control byte is taken MSB first with the layout {1, C2, C1, C0, K2, K1, K0, RW}. The slave acknowledges it only if bit 7 is 1 and {C2,C1,C0} equals {strap2, ~strap1, strap0}. A non-matching byte gets no acknowledge. Every byte after it is ignored until the next start, and the pointer is left unchanged.
- R3: The block bits K2..K0 of a write control byte form address bits 10:8. The following word-address byte forms bits 7:0.
- R4: With protect low, each data byte after the word address is acknowledged and stored at the pointer. The pointer then advances by one.
- R5: With protect high, data bytes are still acknowledged and the pointer still advances, but the array contents do not change.
- R6: A write header, a word address, a repeated start and a read header together return the byte stored at that address.
- R7: A read header sent on its own returns the byte at the current pointer.
- R8: In a read, each master acknowledge (SDA low on the ninth clock) makes the slave send the byte at the next address. After a master no-acknowledge, the slave releases SDA and drives nothing more.
- R9: The pointer wraps from 7FFh to 000h, both in writes and in reads.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | High pulls the open-drain data line low |
| chip_sel_i | input | 3 | Chip-select straps, bit 1 compared inverted |
| wp_i | input | 1 | High makes the array read-only |

## Verification
Two things can fall on the same serial-clock falling edge: committing a data byte to the array and wrapping the pointer from 7FFh to 000h. The bench provokes this with a two-byte write that starts at 7FFh. It judges the result by reading back both 7FFh and 000h with a sequential read, which itself crosses the wrap on a master-acknowledged load. A second coincidence is the protect input held high on the commit edge. There the acknowledge must still appear, the stored byte must stay put, and a later random read proves it.

// File: rtl/sms_pkg.sv
package sms_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CTRL,
      ST_CACK,
      ST_WADR,
      ST_AACK,
      ST_WDAT,
      ST_DACK,
      ST_RDAT,
      ST_RACK
   } sms_state_e;

   localparam int SMS_BYTE_W = 8;
endpackage

// File: rtl/sms_line_sync.sv
module sms_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_q,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [1:0]        line_in;
   logic [STAGES-1:0] chain [2];
   logic              scl_d, sda_d;

   assign line_in = {sda_i, scl_i};

   for (genvar g = 0; g < 2; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[g] <= '1;
         else        chain[g] <= {chain[g][STAGES-2:0], line_in[g]};
      end
   end

   assign scl_q = chain[0][STAGES-1];
   assign sda_q = chain[1][STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_q;
         sda_d <= sda_q;
      end
   end

   assign scl_rise  = scl_q & ~scl_d;
   assign scl_fall  = ~scl_q & scl_d;
   assign start_det = scl_q & scl_d & sda_d & ~sda_q;
   assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/sms_store.sv
module sms_store #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem[addr_i] <= wdata_i;
   end

   assign rdata_o = mem[addr_i];

   // R4
   write_land_chk: assert property (@(posedge clk)
      we_i |=> mem[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/sms_engine.sv
module sms_engine import sms_pkg::*; #(
   parameter int               CHIP_W   = 3,
   parameter int               BLK_W    = 3,
   parameter logic [CHIP_W-1:0] INV_MASK = '0,
   localparam int              ADDR_W   = BLK_W + SMS_BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_q,
   input  logic              sda_q,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [CHIP_W-1:0] strap_i,
   input  logic              wp_i,
   input  logic [7:0]        mem_rdata_i,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [7:0]        mem_wdata_o,
   output logic              sda_oe_o
);
   sms_state_e        state;
   logic [3:0]        cnt;
   logic [7:0]        shreg;
   logic [ADDR_W-1:0] ptr;
   logic [BLK_W-1:0]  blk;
   logic              rw, mack, oe;
   logic              byte_done, hit, commit;

   assign byte_done = (cnt == 4'd8);
   assign hit       = shreg[7] && (shreg[6 -: CHIP_W] == (strap_i ^ INV_MASK));
   assign commit    = (state == ST_WDAT) && scl_fall && byte_done
                      && !stop_det && !start_det;

   assign mem_we_o    = commit && !wp_i;
   assign mem_addr_o  = ptr;
   assign mem_wdata_o = shreg;
   assign sda_oe_o    = oe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         shreg <= '0;
         ptr   <= '0;
         blk   <= '0;
         rw    <= 1'b0;
         mack  <= 1'b0;
         oe    <= 1'b0;
      end else if (stop_det) begin
         state <= ST_IDLE;
         oe    <= 1'b0;
      end else if (start_det) begin
         state <= ST_CTRL;
         cnt   <= '0;
         oe    <= 1'b0;
      end else begin
         case (state)
            ST_CTRL, ST_WADR, ST_WDAT: begin
               if (scl_rise) begin
                  shreg <= {shreg[6:0], sda_q};
                  cnt   <= cnt + 4'd1;
               end else if (scl_fall && byte_done) begin
                  cnt <= '0;
                  if (state == ST_CTRL) begin
                     if (hit) begin
                        state <= ST_CACK;
                        oe    <= 1'b1;
                        rw    <= shreg[0];
                        blk   <= shreg[BLK_W:1];
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else if (state == ST_WADR) begin
                     ptr   <= {blk, shreg};
                     state <= ST_AACK;
                     oe    <= 1'b1;
                  end else begin
                     ptr   <= ptr + ADDR_W'(1);
                     state <= ST_DACK;
                     oe    <= 1'b1;
                  end
               end
            end
            ST_CACK: begin
               if (scl_fall) begin
                  if (rw) begin
                     shreg <= mem_rdata_i;
                     ptr   <= ptr + ADDR_W'(1);
                     oe    <= ~mem_rdata_i[7];
                     cnt   <= '0;
                     state <= ST_RDAT;
                  end else begin
                     oe    <= 1'b0;
                     state <= ST_WADR;
                  end
               end
            end
            ST_AACK, ST_DACK: begin
               if (scl_fall) begin
                  oe    <= 1'b0;
                  state <= ST_WDAT;
               end
            end
            ST_RDAT: begin
               if (scl_fall) begin
                  if (cnt == 4'd7) begin
                     state <= ST_RACK;
                     oe    <= 1'b0;
                     cnt   <= '0;
                  end else begin
                     shreg <= {shreg[6:0], 1'b0};
                     oe    <= ~shreg[6];
                     cnt   <= cnt + 4'd1;
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  mack <= ~sda_q;
               end else if (scl_fall) begin
                  if (mack) begin
                     shreg <= mem_rdata_i;
                     ptr   <= ptr + ADDR_W'(1);
                     oe    <= ~mem_rdata_i[7];
                     cnt   <= '0;
                     state <= ST_RDAT;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   // R1
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE) && !sda_oe_o);

   // R2
   foreign_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CTRL && scl_fall && byte_done && !stop_det && !start_det &&
       (shreg[7:8-CHIP_W-1] != {1'b1, strap_i ^ INV_MASK})) |=> !sda_oe_o);

   // R5
   data_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> sda_oe_o);

   // R9
   ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ptr) == {ADDR_W{1'b1}} && ptr != $past(ptr) && $past(state) != ST_WADR)
      |-> ptr == '0);

   // R10
   sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe_o != $past(sda_oe_o)) |-> !scl_q);
endmodule

// File: rtl/sms_target.sv
module sms_target #(
   parameter int               CHIP_W      = 3,
   parameter int               BLK_W       = 3,
   parameter logic [CHIP_W-1:0] INV_MASK    = 3'b010,
   parameter int               SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic [CHIP_W-1:0] chip_sel_i,
   input  logic              wp_i
);
   localparam int ADDR_W = BLK_W + sms_pkg::SMS_BYTE_W;

   if (CHIP_W + BLK_W != 6) begin : g_bad_layout
      $error("control byte must hold marker, chip, block and direction bits in 8 bits");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic              scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [7:0]        mem_wdata, mem_rdata;

   sms_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_q     (scl_q),
      .sda_q     (sda_q),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   sms_engine #(.CHIP_W(CHIP_W), .BLK_W(BLK_W), .INV_MASK(INV_MASK)) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_q       (scl_q),
      .sda_q       (sda_q),
      .scl_rise    (scl_rise),
      .scl_fall    (scl_fall),
      .start_det   (start_det),
      .stop_det    (stop_det),
      .strap_i     (chip_sel_i),
      .wp_i        (wp_i),
      .mem_rdata_i (mem_rdata),
      .mem_we_o    (mem_we),
      .mem_addr_o  (mem_addr),
      .mem_wdata_o (mem_wdata),
      .sda_oe_o    (sda_oe_o)
   );

   sms_store #(.ADDR_W(ADDR_W), .DATA_W(8)) u_store (
      .clk     (clk),
      .we_i    (mem_we),
      .addr_i  (mem_addr),
      .wdata_i (mem_wdata),
      .rdata_o (mem_rdata)
   );
endmodule

// File: tb/sms_target_test.sv
module sms_target_test;
   localparam int T = 8;

   logic       clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0, wp = 1'b0;
   logic [2:0] straps = 3'b101;
   logic       sda_oe;
   wire        sda_bus = ~(m_low | sda_oe);

   always #10 clk = ~clk;

   sms_target uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl),
      .sda_i      (sda_bus),
      .sda_oe_o   (sda_oe),
      .chip_sel_i (straps),
      .wp_i       (wp)
   );

   int         runs = 0, fails = 0, r10_viol = 0;
   logic [7:0] ref_mem [2048];
   bit         ref_ok  [2048];
   logic [10:0] ref_ptr = '0;
   logic       prev_oe = 1'b0;

   function automatic logic [7:0] ctrl(input bit rd, input logic [2:0] blk, input logic [2:0] chip);
      return {1'b1, chip, blk, rd};
   endfunction
   function automatic logic [2:0] good_chip();
      return straps ^ 3'b010;
   endfunction

   task automatic tick(input int n); repeat (n) @(negedge clk); endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      runs++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
   endtask

   // R10: the slave's drive must never change while the bus clock is high
   always @(negedge clk) begin
      if (rst_n && scl && sda_oe != prev_oe) r10_viol++;
      prev_oe <= sda_oe;
   end

   task automatic i2c_start();
      m_low = 1'b0; tick(T); scl = 1'b1; tick(T); m_low = 1'b1; tick(T); scl = 1'b0; tick(2);
   endtask
   task automatic i2c_stop();
      m_low = 1'b1; tick(T); scl = 1'b1; tick(T); m_low = 1'b0; tick(T);
   endtask
   task automatic put_bit(input bit b);
      m_low = ~b; tick(T); scl = 1'b1; tick(T); scl = 1'b0; tick(2);
   endtask
   task automatic get_bit(output bit b);
      m_low = 1'b0; tick(T); scl = 1'b1; tick(T/2); b = sda_bus; tick(T/2); scl = 1'b0; tick(2);
   endtask
   task automatic send(input logic [7:0] v, output bit acked);
      bit s;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(s);
      acked = ~s;
   endtask
   task automatic recv(input bit ack, output logic [7:0] v);
      bit s;
      for (int i = 7; i >= 0; i--) begin get_bit(s); v[i] = s; end
      put_bit(~ack);
   endtask

   task automatic write_run(input logic [10:0] a, input logic [7:0] d[$], input string req);
      bit ak;
      i2c_start();
      send(ctrl(1'b0, a[10:8], good_chip()), ak); check(ak, "R2 header ack", ak, 1);
      send(a[7:0], ak);                             check(ak, "R3 word addr ack", ak, 1);
      foreach (d[i]) begin
         send(d[i], ak);
         check(ak, req, ak, 1);
         if (!wp) begin ref_mem[a + 11'(i)] = d[i]; ref_ok[a + 11'(i)] = 1'b1; end
      end
      ref_ptr = a + 11'(d.size());
      i2c_stop();
   endtask

   task automatic read_bytes(input int n, input string req);
      logic [7:0] v;
      for (int i = 0; i < n; i++) begin
         recv(i < n - 1, v);
         if (ref_ok[ref_ptr]) check(v == ref_mem[ref_ptr], req, v, ref_mem[ref_ptr]);
         ref_ptr = ref_ptr + 11'd1;
      end
   endtask

   task automatic random_read(input logic [10:0] a, input int n, input string req);
      bit ak;
      i2c_start();
      send(ctrl(1'b0, a[10:8], good_chip()), ak);
      send(a[7:0], ak);
      i2c_start();
      send(ctrl(1'b1, 3'b000, good_chip()), ak); check(ak, "R6 read header ack", ak, 1);
      ref_ptr = a;
      read_bytes(n, req);
      i2c_stop();
   endtask

   task automatic current_read(input int n, input string req);
      bit ak;
      i2c_start();
      send(ctrl(1'b1, 3'b000, good_chip()), ak); check(ak, "R7 read header ack", ak, 1);
      read_bytes(n, req);
      i2c_stop();
   endtask

   initial begin
      tick(200000);
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      finish_up();
   end

   initial begin
      bit         ak, s;
      logic [7:0] q[$];
      logic [10:0] a;
      int         n;
      void'($urandom(32'h5EED_0164));
      tick(5);
      check(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);
      rst_n = 1'b1;
      tick(5);

      // R3: same word address in two blocks holds two different bytes
      q = '{8'hA5};          write_run(11'h5A3, q, "R4 data ack");
      q = '{8'h3C};          write_run(11'h1A3, q, "R4 data ack");
      random_read(11'h5A3, 1, "R3 upper block");
      random_read(11'h1A3, 1, "R3 lower block");

      // R4 / R6 / R7: three bytes, random read of first, current read of rest
      q = '{8'h11, 8'h92, 8'h7E};
      write_run(11'h240, q, "R4 data ack");
      random_read(11'h240, 1, "R6 random read");
      current_read(2, "R7 current read");

      // R8: sequential read, then nothing driven after the no-acknowledge
      random_read(11'h240, 3, "R8 sequential read");
      i2c_start();
      send(ctrl(1'b1, 3'b000, good_chip()), ak);
      ref_ptr = 11'h243;
      q = '{8'h00};
      begin
         logic [7:0] v;
         recv(1'b0, v);
         get_bit(s);
         check(s == 1'b1, "R8 released after nack", s, 1);
      end
      i2c_stop();

      // R9 with a commit on the wrap edge, then a read across it
      q = '{8'hE1, 8'h0F};
      write_run(11'h7FF, q, "R9 data ack");
      check(ref_ptr == 11'h001, "R9 model wrap", ref_ptr, 1);
      random_read(11'h7FF, 2, "R9 read across wrap");
      current_read(1, "R9 pointer after wrap");

      // R5: protect high, ack kept, contents kept
      wp = 1'b1;
      q = '{8'h00, 8'hFF};
      write_run(11'h240, q, "R5 ack under protect");
      wp = 1'b0;
      random_read(11'h240, 2, "R5 contents kept");

      // R2: A1 not inverted -> no ack, later bytes ignored, pointer kept
      random_read(11'h5A3, 1, "R2 pointer setup");
      i2c_start();
      send(ctrl(1'b0, 3'b000, straps), ak); check(!ak, "R2 foreign header", ak, 0);
      send(8'h12, ak);                      check(!ak, "R2 later byte ignored", ak, 0);
      i2c_stop();
      i2c_start();
      send(8'h0E, ak);                      check(!ak, "R2 bad marker bit", ak, 0);
      i2c_stop();
      current_read(1, "R2 pointer unchanged");

      // R1: stop after word address, then a byte without start
      i2c_start();
      send(ctrl(1'b0, 3'b001, good_chip()), ak);
      send(8'hA3, ak);
      i2c_stop();
      send(8'h55, ak);                      check(!ak, "R1 no ack after stop", ak, 0);
      i2c_stop();
      ref_ptr = 11'h1A3;
      current_read(1, "R1 pointer from aborted write");

      // random traffic
      for (int it = 0; it < 10; it++) begin
         a = 11'($urandom % 2048);
         n = 1 + int'($urandom % 3);
         q = {};
         for (int k = 0; k < n; k++) q.push_back(8'($urandom));
         write_run(a, q, "R4 random write ack");
         random_read(a, n, "R6 random readback");
      end

      check(r10_viol == 0, "R10 drive changes with SCL high", r10_viol, 0);
      finish_up();
   end
endmodule